// File: doc/BRIEF.md
# Merging Posted Write Buffer

This block sits between the bus masters of a chip and a slower memory controller. A master presents a doubleword address, 32 bits of data and four byte enables, and when buffering is on the write is taken in the same cycle, provided the buffer is not full. Pending writes are kept in a ring of entries and sent to memory oldest first through a request/acknowledge drain port. Each entry's doubleword address is held in an address-match array. Every incoming write and every read address is compared against all pending entries in one cycle.

A write that hits a pending entry not yet handed to memory is folded into that entry and takes no new slot. Its enabled bytes replace the stored bytes, and the entry's byte mask grows to the union of the old and new enables. A read port returns the memory word with every pending byte laid over it, so a read stays coherent with writes still in the buffer. After reset buffering is off. A write then goes straight to the memory port and completes only when memory acknowledges it. Any entries still pending are flushed first so that the order of writes is kept.

A small state machine drives the memory port. S_IDLE moves to S_DRAIN whenever entries are pending, and otherwise to S_PASS when buffering is off and a write is requested. S_DRAIN presents the oldest entry and returns to S_IDLE on acknowledge. S_PASS presents the master's own write and returns to S_IDLE on acknowledge.

Top module: `mwb_top`

## Requirements
- R1: After reset the buffer holds no entries, buffering is off, mem_req is 0, rd_hit is 0, and wr_rdy is 0 while no write is being passed to memory.
- R2: With buf_en high and fewer than DEPTH entries pending, wr_rdy is 1 in the same cycle wr_req is raised, and the write is taken at that clock edge.
- R3: With DEPTH entries pending, a write that merges into none of them sees wr_rdy 0 until a drain acknowledge frees an entry. A write that hits a mergeable entry is still taken at once.
- R4: A write to the address of a pending entry that is not being drained is merged into it. Byte lane k (bits 8k+7..8k) is replaced where wr_be[k] is 1, the entry mask becomes the OR of old and new enables, and no extra memory transaction results.
- R5: When a later write to a pending address enables a lane already written, the later byte wins and the entry is still sent to memory once.
- R6: Entries go to memory oldest first, one per mem_ack. While mem_ack is low, mem_req stays 1 and mem_addr, mem_wdata and mem_be stay unchanged.
- R7: A write that matches only the entry currently presented on the drain port takes a new entry. Both transactions reach memory in order, each with its own byte mask.
- R8: rd_data takes, in each lane, the byte of the youngest pending write that enables that lane for rd_addr, and otherwise the lane of rd_mem_data. rd_hit is 1 exactly when some entry is pending for rd_addr.
- R9: With buf_en low and nothing pending, a write drives mem_req with the master's address, data and enables, and wr_rdy is 1 only in the cycle of mem_ack.
- R10: If buf_en goes low while entries are pending, a new write stalls until all of them have been acknowledged, and it then passes through after them.
- R11: After any mix of writes and reads, with buffering turned on and off, every read result and the final memory contents equal a byte-granular model that applies each accepted write in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| buf_en | input | 1 | 1 = post writes into the buffer, 0 = pass writes through |
| wr_req | input | 1 | Master write request, held until wr_rdy |
| wr_addr | input | AW | Doubleword address of the write |
| wr_data | input | DW | Write data |
| wr_be | input | NB | Byte enables, bit k for lane k |
| wr_rdy | output | 1 | Write taken at this edge when wr_req is high |
| rd_addr | input | AW | Doubleword address to look up for a read |
| rd_mem_data | input | DW | Memory word at rd_addr |
| rd_data | output | DW | Memory word with pending bytes laid over it |
| rd_hit | output | 1 | Some pending entry matches rd_addr |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | NB | Memory write byte enables |
| mem_ack | input | 1 | Memory has completed the presented write |

## Verification
The bench merges writes into one entry while an older entry for the same address sits locked on the drain port. A design that merged into the locked entry would drop bytes or send a changed word. It fills all entries to check the stall at full and the merge that is still allowed at full. An off-by-one count would overwrite a live entry or stall one slot early. Buffering is switched off with writes pending, and the passing write must land in memory after them. A design that bypassed at once would reorder writes. A long mixed run then checks every read and the final memory against a byte model, which catches a read merge that applies pending entries in the wrong age order.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DRAIN = 2'd1,
        S_PASS  = 2'd2
    } mwb_state_t;
endpackage

// File: rtl/mwb_ctrl.sv
`timescale 1ns/1ps
module mwb_ctrl
    import mwb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          wr_req,
    input  logic          wr_hit,
    input  logic          mem_ack,
    output mwb_state_t    state,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic          wr_rdy,
    output logic          alloc,
    output logic          merge,
    output logic          pop
);
    localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

    mwb_state_t  nxt;
    logic [IW:0] count;
    logic        empty, full, pass, acc;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (!empty)                nxt = S_DRAIN;
                else if (!buf_en && wr_req) nxt = S_PASS;
            end
            S_DRAIN: if (mem_ack) nxt = S_IDLE;
            S_PASS:  if (mem_ack) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pass   = (state == S_PASS);
        wr_rdy = pass ? mem_ack : (buf_en && (wr_hit || !full));
        acc    = !pass && buf_en && wr_req && (wr_hit || !full);
        alloc  = acc && !wr_hit;
        merge  = acc && wr_hit;
        pop    = (state == S_DRAIN) && mem_ack;
    end

    // state register and ring pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            state <= nxt;
            if (alloc) tail <= tail + 1'b1;
            if (pop)   head <= head + 1'b1;
            count <= count + (IW+1)'(alloc) - (IW+1)'(pop);
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r6_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN && !mem_ack) |=> (state == S_DRAIN));
    a_r10_pass_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS) |-> empty);
    a_r2_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && state != S_PASS && wr_req && !full) |-> wr_rdy);
endmodule

// File: rtl/mwb_cam.sv
`timescale 1ns/1ps
module mwb_cam #(
    parameter int DEPTH = 32,
    parameter int AW    = 30,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic [IW-1:0]             alloc_idx,
    input  logic [AW-1:0]             alloc_addr,
    input  logic                      pop,
    input  logic [IW-1:0]             pop_idx,
    input  logic                      lock,
    input  logic [IW-1:0]             lock_idx,
    input  logic [AW-1:0]             rd_addr,
    output logic [DEPTH-1:0]          wr_hit_vec,
    output logic [DEPTH-1:0]          rd_vec,
    output logic [DEPTH-1:0][AW-1:0]  tags
);
    logic [DEPTH-1:0] valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
            tags  <= '0;
        end else begin
            if (pop) begin
                valid[pop_idx] <= 1'b0;
                tags[pop_idx]  <= '0;
            end
            if (alloc) begin
                valid[alloc_idx] <= 1'b1;
                tags[alloc_idx]  <= alloc_addr;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign wr_hit_vec[i] = valid[i] && (tags[i] == alloc_addr)
                             && !(lock && (lock_idx == IW'(i)));
        assign rd_vec[i]     = valid[i] && (tags[i] == rd_addr);
    end

    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit_vec));
    a_r6_pop_live: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid[pop_idx]);
    a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !valid[alloc_idx]);
endmodule

// File: rtl/mwb_store.sv
`timescale 1ns/1ps
module mwb_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    parameter int NB    = DW/8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic [IW-1:0]             alloc_idx,
    input  logic [DEPTH-1:0]          merge_vec,
    input  logic [DW-1:0]             wr_data,
    input  logic [NB-1:0]             wr_be,
    output logic [DEPTH-1:0][DW-1:0]  data_q,
    output logic [DEPTH-1:0][NB-1:0]  be_q
);
    function automatic logic [DW-1:0] lanes(input logic [NB-1:0] b);
        for (int j = 0; j < NB; j++) lanes[8*j +: 8] = {8{b[j]}};
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                be_q[i]   <= '0;
            end else if (alloc && alloc_idx == IW'(i)) begin
                data_q[i] <= wr_data;
                be_q[i]   <= wr_be;
            end else if (merge_vec[i]) begin
                for (int b = 0; b < NB; b++)
                    if (wr_be[b]) data_q[i][8*b +: 8] <= wr_data[8*b +: 8];
                be_q[i] <= be_q[i] | wr_be;
            end
        end

        a_r4_merge_bytes: assert property (@(posedge clk) disable iff (!rst_n)
            merge_vec[i] |=> (((be_q[i] & $past(wr_be)) == $past(wr_be)) &&
                ((data_q[i] & lanes($past(wr_be))) == ($past(wr_data) & lanes($past(wr_be))))));
        a_r5_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
            merge_vec[i] |=> ((be_q[i] & $past(be_q[i])) == $past(be_q[i])));
    end
endmodule

// File: rtl/mwb_rdmerge.sv
`timescale 1ns/1ps
module mwb_rdmerge #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    parameter int NB    = DW/8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]             head,
    input  logic [DEPTH-1:0]          rd_vec,
    input  logic [DEPTH-1:0][DW-1:0]  data_q,
    input  logic [DEPTH-1:0][NB-1:0]  be_q,
    input  logic [DW-1:0]             rd_mem_data,
    output logic [DW-1:0]             rd_data,
    output logic                      rd_hit
);
    // walk from oldest to youngest so younger bytes override older ones
    always_comb begin
        logic [IW-1:0] idx;
        rd_data = rd_mem_data;
        rd_hit  = 1'b0;
        idx     = head;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IW'(k);
            if (rd_vec[idx]) begin
                rd_hit = 1'b1;
                for (int b = 0; b < NB; b++)
                    if (be_q[idx][b]) rd_data[8*b +: 8] = data_q[idx][8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/mwb_top.sv
`timescale 1ns/1ps
module mwb_top
    import mwb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int NB    = DW/8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_be,
    output logic          wr_rdy,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_mem_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_hit,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [NB-1:0] mem_be,
    input  logic          mem_ack
);
    mwb_state_t               state;
    logic [IW-1:0]            head, tail;
    logic                     alloc, merge, pop, lock, wr_hit;
    logic [DEPTH-1:0]         wr_hit_vec, rd_vec;
    logic [DEPTH-1:0][AW-1:0] tags;
    logic [DEPTH-1:0][DW-1:0] data_q;
    logic [DEPTH-1:0][NB-1:0] be_q;

    assign lock   = (state == S_DRAIN);
    assign wr_hit = |wr_hit_vec;

    mwb_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wr_req(wr_req),
        .wr_hit(wr_hit), .mem_ack(mem_ack), .state(state), .head(head),
        .tail(tail), .wr_rdy(wr_rdy), .alloc(alloc), .merge(merge), .pop(pop)
    );

    mwb_cam #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_cam (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_idx(tail),
        .alloc_addr(wr_addr), .pop(pop), .pop_idx(head), .lock(lock),
        .lock_idx(head), .rd_addr(rd_addr), .wr_hit_vec(wr_hit_vec),
        .rd_vec(rd_vec), .tags(tags)
    );

    mwb_store #(.DEPTH(DEPTH), .DW(DW), .NB(NB), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_idx(tail),
        .merge_vec(wr_hit_vec & {DEPTH{merge}}), .wr_data(wr_data),
        .wr_be(wr_be), .data_q(data_q), .be_q(be_q)
    );

    mwb_rdmerge #(.DEPTH(DEPTH), .DW(DW), .NB(NB), .IW(IW)) u_rdm (
        .head(head), .rd_vec(rd_vec), .data_q(data_q), .be_q(be_q),
        .rd_mem_data(rd_mem_data), .rd_data(rd_data), .rd_hit(rd_hit)
    );

    // memory port: oldest entry while draining, master write while passing
    always_comb begin
        mem_req = lock || (state == S_PASS);
        if (state == S_PASS) begin
            mem_addr  = wr_addr;
            mem_wdata = wr_data;
            mem_be    = wr_be;
        end else begin
            mem_addr  = tags[head];
            mem_wdata = data_q[head];
            mem_be    = be_q[head];
        end
    end

    a_r6_drain_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                $stable(mem_wdata) && $stable(mem_be)));
endmodule

// File: tb/sim_mwb_top.sv
`timescale 1ns/1ps
module sim_mwb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_en = 1'b0;
    logic        wr_req = 1'b0;
    logic [29:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_rdy;
    logic [29:0] rd_addr = '0;
    logic [31:0] rd_mem_data;
    logic [31:0] rd_data;
    logic        rd_hit;
    logic        mem_req;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack;

    logic [31:0] mem  [0:63];
    logic [31:0] refm [0:63];
    logic [29:0] tx_addr [0:511];
    logic [31:0] tx_data [0:511];
    logic [3:0]  tx_be   [0:511];
    int tx_n = 0;
    int lat  = 1;
    bit hold = 1'b0;
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    assign rd_mem_data = mem[rd_addr[5:0]];

    mwb_top u0 (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_rdy(wr_rdy),
        .rd_addr(rd_addr), .rd_mem_data(rd_mem_data), .rd_data(rd_data),
        .rd_hit(rd_hit), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack)
    );

    // memory responder: acts one time unit after each falling edge
    initial begin
        int cnt;
        cnt = 0;
        mem_ack = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA5A5A5A5 ^ (i * 32'h01010101);
        forever begin
            @(negedge clk);
            #1;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && !hold) begin
                if (cnt >= lat) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[5:0]][8*b +: 8] = mem_wdata[8*b +: 8];
                    tx_addr[tx_n % 512] = mem_addr;
                    tx_data[tx_n % 512] = mem_wdata;
                    tx_be[tx_n % 512]   = mem_be;
                    tx_n++;
                    mem_ack = 1'b1;
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [29:0] a, input logic [31:0] d, input logic [3:0] b, output int waits);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_be = b; wr_req = 1'b1;
        waits = 0;
        #2;
        while (!wr_rdy && waits < 3000) begin
            @(negedge clk); #2; waits++;
        end
        @(posedge clk);
        if (waits < 3000)
            for (int k = 0; k < 4; k++)
                if (b[k]) refm[a[5:0]][8*k +: 8] = d[8*k +: 8];
        #1 wr_req = 1'b0;
    endtask

    task automatic rd_chk(input logic [29:0] a, input int exp_hit, input string req);
        @(negedge clk);
        rd_addr = a;
        #2;
        chk(rd_data == refm[a[5:0]], req, rd_data, refm[a[5:0]]);
        if (exp_hit >= 0) chk(rd_hit == exp_hit[0], req, rd_hit, exp_hit);
    endtask

    task automatic wait_drain();
        int quiet, guard;
        quiet = 0; guard = 0;
        while (quiet < 8 && guard < 5000) begin
            @(negedge clk); #2;
            if (mem_req) quiet = 0; else quiet++;
            guard++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #2;
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        chk(wr_rdy == 1'b0, "R1 wr_rdy", wr_rdy, 0);
        chk(rd_hit == 1'b0, "R1 rd_hit", rd_hit, 0);
    endtask

    task automatic t_pass();
        int w, base;
        base = tx_n; lat = 2; buf_en = 1'b0;
        wr(30'h08, 32'h12345678, 4'b1011, w);
        chk(w >= 1 && w < 3000, "R9 waits on memory", w, 1);
        chk(tx_n == base + 1, "R9 one transaction", tx_n - base, 1);
        chk(tx_addr[base % 512] == 30'h08 && tx_be[base % 512] == 4'b1011 &&
            tx_data[base % 512] == 32'h12345678, "R9 fields", tx_addr[base % 512], 30'h08);
        rd_chk(30'h08, 0, "R9 memory updated");
    endtask

    task automatic t_merge();
        int w, base;
        buf_en = 1'b1; hold = 1'b1; lat = 1; base = tx_n;
        wr(30'h10, 32'h01020304, 4'b1111, w); chk(w == 0, "R2 zero wait", w, 0);
        wr(30'h11, 32'h000000AA, 4'b0001, w); chk(w == 0, "R2 zero wait", w, 0);
        wr(30'h11, 32'h00CC0000, 4'b0100, w); chk(w == 0, "R4 merge zero wait", w, 0);
        wr(30'h11, 32'h000000EE, 4'b0001, w); chk(w == 0, "R5 collapse zero wait", w, 0);
        wr(30'h10, 32'h0000BEEF, 4'b0011, w); chk(w == 0, "R7 write to locked", w, 0);
        chk(tx_n == base, "R2 nothing drained while held", tx_n - base, 0);
        rd_chk(30'h11, 1, "R8 merged read");
        rd_chk(30'h10, 1, "R8 youngest wins");
        rd_chk(30'h20, 0, "R8 miss");
        hold = 1'b0;
        wait_drain();
        chk(tx_n == base + 3, "R4 three transactions", tx_n - base, 3);
        chk(tx_addr[base % 512] == 30'h10 && tx_be[base % 512] == 4'hF, "R6 oldest first",
            tx_addr[base % 512], 30'h10);
        chk(tx_addr[(base+1) % 512] == 30'h11 && tx_be[(base+1) % 512] == 4'b0101,
            "R4 merged mask", tx_be[(base+1) % 512], 4'b0101);
        chk((tx_data[(base+1) % 512] & 32'h00FF00FF) == 32'h00CC00EE, "R5 later byte wins",
            tx_data[(base+1) % 512] & 32'h00FF00FF, 32'h00CC00EE);
        chk(tx_addr[(base+2) % 512] == 30'h10 && tx_be[(base+2) % 512] == 4'b0011,
            "R7 separate entry", tx_be[(base+2) % 512], 4'b0011);
        rd_chk(30'h10, 0, "R7 memory after drain");
        rd_chk(30'h11, 0, "R4 memory after drain");
    endtask

    task automatic t_full();
        int w, base, maxw;
        bit ord_ok;
        hold = 1'b1; base = tx_n; maxw = 0;
        for (int i = 0; i < 32; i++) begin
            wr(30'h20 + 30'(i), 32'h11110000 + 32'(i), 4'hF, w);
            if (w > maxw) maxw = w;
        end
        chk(maxw == 0, "R2 zero wait up to full", maxw, 0);
        wr(30'h21, 32'h00007700, 4'b0010, w);
        chk(w == 0, "R3 merge allowed at full", w, 0);
        fork
            begin repeat (5) @(negedge clk); hold = 1'b0; end
            wr(30'h00, 32'hCAFEF00D, 4'hF, w);
        join
        chk(w >= 5 && w < 3000, "R3 stall at full", w, 5);
        wait_drain();
        chk(tx_n == base + 33, "R3 transaction count", tx_n - base, 33);
        ord_ok = 1'b1;
        for (int i = 0; i < 32; i++)
            if (tx_addr[(base+i) % 512] != 30'h20 + 30'(i)) ord_ok = 1'b0;
        if (tx_addr[(base+32) % 512] != 30'h00) ord_ok = 1'b0;
        chk(ord_ok, "R6 drain order", ord_ok, 1);
        rd_chk(30'h21, 0, "R3 merged at full");
    endtask

    task automatic t_disable_pending();
        int w, base;
        buf_en = 1'b1; hold = 1'b1; base = tx_n;
        wr(30'h05, 32'h55555555, 4'hF, w);
        wr(30'h06, 32'h66666666, 4'hF, w);
        @(negedge clk); buf_en = 1'b0;
        fork
            begin repeat (6) @(negedge clk); hold = 1'b0; end
            wr(30'h07, 32'h77777777, 4'hF, w);
        join
        chk(w >= 6 && w < 3000, "R10 stall until flushed", w, 6);
        wait_drain();
        chk(tx_n == base + 3 && tx_addr[base % 512] == 30'h05 &&
            tx_addr[(base+1) % 512] == 30'h06 && tx_addr[(base+2) % 512] == 30'h07,
            "R10 order kept", tx_addr[(base+2) % 512], 30'h07);
        rd_chk(30'h07, 0, "R10 pass write landed");
    endtask

    task automatic t_random();
        int w, bad;
        hold = 1'b0; buf_en = 1'b1;
        for (int n = 0; n < 400; n++) begin
            lat = $urandom_range(0, 3);
            if (n % 50 == 49) buf_en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0)
                rd_chk(30'h30 + 30'($urandom_range(0, 7)), -1, "R11 random read");
            else
                wr(30'h30 + 30'($urandom_range(0, 7)), $urandom(),
                   4'($urandom_range(1, 15)), w);
        end
        wait_drain();
        bad = 0;
        for (int i = 0; i < 64; i++) if (mem[i] != refm[i]) bad++;
        chk(bad == 0, "R11 final memory", bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) refm[i] = 32'hA5A5A5A5 ^ (i * 32'h01010101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_merge();
        t_full();
        t_disable_pending();
        t_random();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end
endmodule